// File: doc/BRIEF.md
# Cache Line Coherence State Tracker

This block holds the four-state coherence state of every line in a small cache, one entry per line index. Each clock cycle it may take in a single event: a read or write issued by the local processor, or a read or write by another agent that was observed on the shared bus. Each event carries a line index. The block moves that one line to its next state. It also raises two single-cycle side-band pulses. The first asks the local cache to drive the dirty line out, both to the requesting agent and back to memory. The second announces an ownership request to the other agents.

This variant is simplified. A local read that misses always fills the line as Shared, never as Exclusive. Because of that, no event can ever bring a line into Exclusive. The only write that sends an ownership request is the upgrade from Shared to Modified. Data storage, tag lookup and bus arbitration belong to the surrounding cache. The full state vector is exposed so that those parts, or a debugger, can read any line.

Top module: `coh_state_tracker`

## Requirements
- R1: After reset, every line reads Invalid and both side-band pulses are low.
- R2: Each line state occupies bits [2i+1:2i] of `lineStates`, encoded Invalid=00, Shared=01, Exclusive=10, Modified=11. The code 10 never appears on any line.
- R3: A local read (`evtKind`=00) moves an Invalid line to Shared and leaves Shared and Modified lines unchanged.
- R4: A local write (`evtKind`=01) moves the line to Modified from any state. When the line was Shared, it also pulses `rfoNotice`.
- R5: A remote read (`evtKind`=10) moves Modified or Exclusive to Shared and leaves Shared and Invalid unchanged. When the line was Modified, it also pulses `supplyData`.
- R6: A remote write (`evtKind`=11) moves every line state to Invalid. When the line was Modified, it also pulses `supplyData`.
- R7: Only the addressed line changes. While `evtValid` is low, no line changes and no pulse is raised.
- R8: The state change and its pulse appear together after the clock edge that accepts the event, and each pulse lasts exactly one cycle.
- R9: `rfoNotice` rises only for a local write to a Shared line. `supplyData` rises only for a remote event that hits a Modified line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; all lines become Invalid |
| evtValid | input | 1 | An event is presented this cycle |
| evtKind | input | 2 | 00 local read, 01 local write, 10 remote read, 11 remote write |
| evtIdx | input | $clog2(NUM_LINES) | Line index of the event |
| lineStates | output | 2*NUM_LINES | Packed state of all lines, line i in bits [2i+1:2i] |
| supplyData | output | 1 | One-cycle pulse: drive the dirty line to requester and memory |
| rfoNotice | output | 1 | One-cycle pulse: broadcast ownership request |

## Verification
A wrong stored state shows up on `lineStates` in the cycle right after the faulty event, because every line is visible at the ports. It also corrupts what later events produce. For example, a line left in Modified when it should be Shared raises a false `supplyData` on the next remote access to it. A missing Shared state silently drops the `rfoNotice` on the next local write. The sweep visits every reachable state with every event on every index. Any error is therefore seen within one cycle, either on the state vector or on a pulse.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    ST_INV = 2'b00,
    ST_SHR = 2'b01,
    ST_EXC = 2'b10,
    ST_MOD = 2'b11
  } lineSt_t;

  typedef enum logic [1:0] {
    EV_LRD = 2'b00,
    EV_LWR = 2'b01,
    EV_RRD = 2'b10,
    EV_RWR = 2'b11
  } evt_t;

  // strobes from control to the state store
  typedef struct packed {
    logic    wrEn;
    lineSt_t nextSt;
    logic    supply;
    logic    rfo;
  } ctrlStb_t;

endpackage

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
(
  input  logic       evtValid,
  input  logic [1:0] evtKind,
  input  lineSt_t    curSt,
  output ctrlStb_t   stb
);

  evt_t kind;
  assign kind = evt_t'(evtKind);

  always_comb begin
    stb.wrEn   = evtValid;
    stb.nextSt = curSt;
    stb.supply = 1'b0;
    stb.rfo    = 1'b0;
    if (evtValid) begin
      unique case (kind)
        EV_LRD: begin
          // miss fills as Shared; hits keep their state
          if (curSt == ST_INV) stb.nextSt = ST_SHR;
        end
        EV_LWR: begin
          stb.nextSt = ST_MOD;
          stb.rfo    = (curSt == ST_SHR);
        end
        EV_RRD: begin
          if (curSt == ST_MOD || curSt == ST_EXC) stb.nextSt = ST_SHR;
          stb.supply = (curSt == ST_MOD);
        end
        EV_RWR: begin
          stb.nextSt = ST_INV;
          stb.supply = (curSt == ST_MOD);
        end
        default: stb.nextSt = curSt;
      endcase
    end
  end

endmodule

// File: rtl/coh_store.sv
module coh_store
  import coh_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  ctrlStb_t               stb,
  input  logic [IDX_W-1:0]       evtIdx,
  output lineSt_t                curSt,
  output logic [2*NUM_LINES-1:0] lineStates,
  output logic                   supplyData,
  output logic                   rfoNotice
);

  lineSt_t stArr [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stArr[g] <= ST_INV;
      end else if (stb.wrEn && (evtIdx == IDX_W'(g))) begin
        stArr[g] <= stb.nextSt;
      end
    end
    assign lineStates[2*g +: 2] = stArr[g];
  end

  // read port for the addressed line
  always_comb begin
    curSt = ST_INV;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (evtIdx == IDX_W'(i)) curSt = stArr[i];
    end
  end

  // side-band pulses registered with the state update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      supplyData <= 1'b0;
      rfoNotice  <= 1'b0;
    end else begin
      supplyData <= stb.supply;
      rfoNotice  <= stb.rfo;
    end
  end

endmodule

// File: rtl/coh_state_tracker.sv
module coh_state_tracker
  import coh_pkg::*;
#(
  parameter  int NUM_LINES = 8,
  localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   evtValid,
  input  logic [1:0]             evtKind,
  input  logic [IDX_W-1:0]       evtIdx,
  output logic [2*NUM_LINES-1:0] lineStates,
  output logic                   supplyData,
  output logic                   rfoNotice
);

  lineSt_t  curSt;
  ctrlStb_t stb;

  coh_ctrl uCtrl (
    .evtValid (evtValid),
    .evtKind  (evtKind),
    .curSt    (curSt),
    .stb      (stb)
  );

  coh_store #(
    .NUM_LINES (NUM_LINES),
    .IDX_W     (IDX_W)
  ) uStore (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .evtIdx     (evtIdx),
    .curSt      (curSt),
    .lineStates (lineStates),
    .supplyData (supplyData),
    .rfoNotice  (rfoNotice)
  );

endmodule

// File: rtl/coh_chk.sv
module coh_chk #(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   evtValid,
  input logic [1:0]             evtKind,
  input logic [IDX_W-1:0]       evtIdx,
  input logic [2*NUM_LINES-1:0] lineStates,
  input logic                   supplyData,
  input logic                   rfoNotice
);

  logic             vQ;
  logic [1:0]       kQ;
  logic [IDX_W-1:0] idxQ;
  logic [1:0]       sQ;
  logic [1:0]       curNow;
  logic [1:0]       curAtIdxQ;

  always_comb begin
    curNow    = 2'b00;
    curAtIdxQ = 2'b00;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (evtIdx == IDX_W'(i)) curNow    = lineStates[2*i +: 2];
      if (idxQ   == IDX_W'(i)) curAtIdxQ = lineStates[2*i +: 2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vQ   <= 1'b0;
      kQ   <= 2'b00;
      idxQ <= '0;
      sQ   <= 2'b00;
    end else begin
      vQ   <= evtValid;
      kQ   <= evtKind;
      idxQ <= evtIdx;
      sQ   <= curNow;
    end
  end

  AST_LRD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (vQ && kQ == 2'b00) |-> (curAtIdxQ == ((sQ == 2'b00) ? 2'b01 : sQ))); // R3
  AST_LWR_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    (vQ && kQ == 2'b01) |-> (curAtIdxQ == 2'b11)); // R4
  AST_RRD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (vQ && kQ == 2'b10) |-> (curAtIdxQ == ((sQ == 2'b00) ? 2'b00 : 2'b01))); // R5
  AST_RWR_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (vQ && kQ == 2'b11) |-> (curAtIdxQ == 2'b00)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !evtValid |=> ($stable(lineStates) && !supplyData && !rfoNotice)); // R7
  AST_RFO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    rfoNotice |-> (vQ && kQ == 2'b01 && sQ == 2'b01)); // R9
  AST_SUPPLY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    supplyData |-> (vQ && kQ[1] && sQ == 2'b11)); // R9
  AST_SUPPLY_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    (vQ && kQ[1] && sQ == 2'b11) |-> supplyData); // R8

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        AST_NO_EXCL: assert (lineStates[2*i +: 2] != 2'b10); // R2
      end
    end
  end

endmodule

bind coh_state_tracker coh_chk #(
  .NUM_LINES (NUM_LINES),
  .IDX_W     (IDX_W)
) uChk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evtValid   (evtValid),
  .evtKind    (evtKind),
  .evtIdx     (evtIdx),
  .lineStates (lineStates),
  .supplyData (supplyData),
  .rfoNotice  (rfoNotice)
);

// File: tb/sim_coh_state_tracker.sv
module sim_coh_state_tracker;

  localparam int NL = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          evtValid = 1'b0;
  logic [1:0]    evtKind = 2'b00;
  logic [IW-1:0] evtIdx = '0;
  logic [2*NL-1:0] lineStates;
  logic          supplyData;
  logic          rfoNotice;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [1:0] mdl [NL];

  always #4 clk = ~clk;

  coh_state_tracker #(.NUM_LINES(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .evtValid(evtValid), .evtKind(evtKind),
    .evtIdx(evtIdx), .lineStates(lineStates), .supplyData(supplyData),
    .rfoNotice(rfoNotice)
  );

  function automatic logic [1:0] nxtSt(input logic [1:0] st, input logic [1:0] k);
    case (k)
      2'b00:   return (st == 2'b00) ? 2'b01 : st;
      2'b01:   return 2'b11;
      2'b10:   return (st == 2'b00) ? 2'b00 : 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic string stTag(input logic v, input logic [1:0] k);
    if (!v) return "R7";
    case (k)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fullVec(output logic [2*NL-1:0] v);
    for (int i = 0; i < NL; i++) v[2*i +: 2] = mdl[i];
  endtask

  // drive at negedge, accepted at posedge, sampled at next negedge
  task automatic doEvt(input logic v, input logic [1:0] k, input int idx);
    logic [1:0] prev;
    logic expSup, expRfo;
    logic [2*NL-1:0] expVec;
    logic sawExc;
    evtValid = v;
    evtKind  = k;
    evtIdx   = IW'(idx);
    prev   = mdl[idx];
    expSup = v && k[1] && (prev == 2'b11);
    expRfo = v && (k == 2'b01) && (prev == 2'b01);
    if (v) mdl[idx] = nxtSt(prev, k);
    @(posedge clk);
    @(negedge clk);
    fullVec(expVec);
    check(stTag(v, k), 32'(lineStates), 32'(expVec));
    check(expSup ? "R5/R6 supply" : "R9 supply", 32'(supplyData), 32'(expSup));
    check(expRfo ? "R4 rfo" : "R9 rfo", 32'(rfoNotice), 32'(expRfo));
    sawExc = 1'b0;
    for (int i = 0; i < NL; i++) if (lineStates[2*i +: 2] == 2'b10) sawExc = 1'b1;
    check("R2 no exclusive code", 32'(sawExc), 32'd0);
    evtValid = 1'b0;
  endtask

  task automatic setState(input int idx, input logic [1:0] st);
    doEvt(1'b1, 2'b11, idx);
    if (st == 2'b01) doEvt(1'b1, 2'b00, idx);
    if (st == 2'b11) doEvt(1'b1, 2'b01, idx);
  endtask

  initial begin
    for (int i = 0; i < NL; i++) mdl[i] = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 lines", 32'(lineStates), 32'd0);
    check("R1 supply", 32'(supplyData), 32'd0);
    check("R1 rfo", 32'(rfoNotice), 32'd0);

    // mixed background so neighbours are visibly untouched (R7)
    for (int i = 0; i < NL; i++) setState(i, (i % 3 == 0) ? 2'b00 : ((i % 3 == 1) ? 2'b01 : 2'b11));

    // idle with write kind presented: nothing moves (R7)
    for (int i = 0; i < NL; i++) doEvt(1'b0, 2'b01, i);

    // exhaustive sweep: line x reachable state x event
    for (int idx = 0; idx < NL; idx++) begin
      for (int s = 0; s < 3; s++) begin
        for (int k = 0; k < 4; k++) begin
          logic [1:0] st;
          st = (s == 0) ? 2'b00 : ((s == 1) ? 2'b01 : 2'b11);
          setState(idx, st);
          doEvt(1'b1, 2'(k), idx);
          // pulse must drop the cycle after (R8)
          doEvt(1'b0, 2'(k), idx);
        end
      end
    end

    // back-to-back upgrades on different lines: pulses on consecutive cycles (R8)
    setState(1, 2'b01);
    setState(2, 2'b01);
    doEvt(1'b1, 2'b01, 1);
    doEvt(1'b1, 2'b01, 2);
    doEvt(1'b1, 2'b10, 1);
    doEvt(1'b1, 2'b11, 2);
    doEvt(1'b0, 2'b00, 0);

    // reset in mid run returns all to Invalid (R1)
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NL; i++) mdl[i] = 2'b00;
    @(negedge clk);
    check("R1 lines after reset", 32'(lineStates), 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule